// File: doc/BRIEF.md
# Auto-Baud Rate Detector

This block sits beside an asynchronous serial receiver and works out the line rate from a sync character that the far end sends. The line is idle high. When alignment is enabled, the block times the start bit in system clocks. The sync characters have their least significant data bit set, so the low time of the start bit is exactly one bit period. The block then uses that period to sample the rest of the character at mid-bit. The rate counts as found only when the decoded byte is an upper- or lower-case letter A and the stop bit is high.

A successful lock does three things. It publishes the measured period as a divisor, it gives a one-cycle valid pulse, and it sets a sticky completion flag. Software clears the flag by writing 1 to a clear control. Writing 0 to that control does nothing, and the control always reads back as 0. A start width that is too short counts as a glitch and is ignored. A wrong character or a missing stop bit discards the measurement, and the block waits for the next falling edge.

Top module: `autobaud_detect`

## Requirements
- R1: `lock_flag_o` rises only in the cycle after a `divisor_vld_o` pulse. It stays high until it is cleared. A lock needs the byte 0x41 or 0x61, received least significant bit first, followed by a high stop bit.
- R2: A write (`abd_clr_wr_i`=1) with `abd_clr_data_i`=1 makes `lock_flag_o` 0 from the next cycle, unless a lock completes in that same cycle. A lock takes priority over a clear.
- R3: A write with `abd_clr_data_i`=0 leaves `lock_flag_o` unchanged.
- R4: `clr_rdata_o` is 0 in every cycle, including while a clear is being written.
- R5: While `align_en_i` is 0 there is no measurement, no valid pulse and no flag set. Dropping `align_en_i` during a character abandons that character.
- R6: While `rst_n` is low, `lock_flag_o`, `divisor_o`, `divisor_vld_o` and `clr_rdata_o` are all 0.
- R7: The measured period P is the number of clocks on which `rx_i` is sampled low, counted from the first low sample. `divisor_o` takes the value P, and `divisor_vld_o` is high for exactly one cycle, after clock edge c+9P+floor(P/2)+2, where c is the first edge that samples `rx_i` low. `divisor_o` holds its value between locks.
- R8: A start width below 4 clocks is rejected without effect. A width of exactly 4 is accepted as a period.
- R9: A byte other than 0x41 or 0x61, or a low stop bit, gives no valid pulse and no flag change. A later correct character still locks.
- R10: The eight data bits are each sampled at mid-bit, at floor(P/2) clocks into the bit, using the measured period. The first data bit sampled is the least significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| align_en_i | input | 1 | Enables auto-baud alignment |
| abd_clr_wr_i | input | 1 | Write strobe for the clear control |
| abd_clr_data_i | input | 1 | Value written to the clear control; 1 clears the flag |
| lock_flag_o | output | 1 | Sticky completion flag |
| divisor_o | output | CNT_W | Measured bit period in system clocks |
| divisor_vld_o | output | 1 | One-cycle pulse when a new divisor is locked |
| clr_rdata_o | output | 1 | Readback of the clear control, always 0 |

## Verification
The assertions check the following on every cycle:
- the flag rises only after a valid pulse, and the flag is sticky;
- a clear write of 1 empties the flag, and a clear write of 0 leaves it alone;
- the clear readback is 0;
- there is no valid pulse while alignment is disabled;
- the valid pulse lasts a single cycle;
- the divisor stays stable between locks and never falls below the minimum.

Some behaviour only the bench scenarios can show, because it depends on the whole serial frame the bench drives and on a model that predicts the exact lock cycle:
- the measured period equals the start width;
- sampling happens at mid-bit;
- only the two sync letters are accepted;
- framing errors and short glitches are rejected;
- a frame disabled partway through is abandoned.

// File: rtl/abd_pkg.sv
// Shared definitions for the auto-baud detector: frame state encoding,
// character width and the two accepted sync characters.
package abd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_MEASURE = 2'd1,
        ST_DATA    = 2'd2,
        ST_STOP    = 2'd3
    } abd_state_e;

    localparam int ABD_DATA_BITS = 8;
    localparam logic [ABD_DATA_BITS-1:0] ABD_SYNC_UPPER = 8'h41;
    localparam logic [ABD_DATA_BITS-1:0] ABD_SYNC_LOWER = 8'h61;

    // True when the decoded byte is one of the accepted sync letters.
    function automatic logic abd_is_sync(input logic [ABD_DATA_BITS-1:0] chr);
        return (chr == ABD_SYNC_UPPER) || (chr == ABD_SYNC_LOWER);
    endfunction

endpackage

// File: rtl/abd_line_sync.sv
// Brings the asynchronous receive line into the clock domain through
// SYNC_STAGES flip-flops and flags falling and rising edges of the
// synchronised level. Assumes an idle-high line, so reset loads ones.
module abd_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_async,
    output logic rx_level,
    output logic rx_fall,
    output logic rx_rise
);

    logic [SYNC_STAGES:0] pipe_q;

    // Shift the line through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[SYNC_STAGES-1:0], rx_async};
        end
    end

    // Edge flags compare the synchronised level with the stage behind it.
    always_comb begin
        rx_level = pipe_q[SYNC_STAGES-1];
        rx_fall  = pipe_q[SYNC_STAGES] & ~pipe_q[SYNC_STAGES-1];
        rx_rise  = ~pipe_q[SYNC_STAGES] & pipe_q[SYNC_STAGES-1];
    end

endmodule

// File: rtl/abd_frame_fsm.sv
// Times the start bit of a sync character, then samples the data bits and
// the stop bit at mid-bit with that period. Emits a registered one-cycle
// lock pulse and the accepted period when the character is a sync letter
// with a high stop bit. Assumes the first data bit of the character is 1,
// so the start-bit low time equals one bit period. MIN_PERIOD >= 2.
module abd_frame_fsm
    import abd_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int MIN_PERIOD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             rx_level,
    input  logic             rx_fall,
    input  logic             rx_rise,
    output logic             lock_pulse,
    output logic [CNT_W-1:0] lock_period
);

    localparam int                 BIT_W    = $clog2(ABD_DATA_BITS);
    localparam logic [CNT_W-1:0]   CNT_MAX  = '1;
    localparam logic [CNT_W-1:0]   CNT_MIN  = CNT_W'(MIN_PERIOD);
    localparam logic [CNT_W-1:0]   CNT_ONE  = CNT_W'(1);
    localparam logic [BIT_W-1:0]   LAST_BIT = BIT_W'(ABD_DATA_BITS - 1);

    abd_state_e               state_q;
    logic [CNT_W-1:0]         width_q;
    logic [CNT_W-1:0]         period_q;
    logic [CNT_W-1:0]         tick_q;
    logic [BIT_W-1:0]         bit_idx_q;
    logic [ABD_DATA_BITS-1:0] shift_q;
    logic                     pulse_q;
    logic [CNT_W-1:0]         out_period_q;
    logic                     tick_done;
    logic                     char_ok;

    // Sample point reached and decoded-character check.
    always_comb begin
        tick_done = (tick_q == '0);
        char_ok   = abd_is_sync(shift_q);
    end

    // Frame sequencer: measure, sample data, check stop, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            width_q      <= '0;
            period_q     <= '0;
            tick_q       <= '0;
            bit_idx_q    <= '0;
            shift_q      <= '0;
            pulse_q      <= 1'b0;
            out_period_q <= '0;
        end else begin
            pulse_q <= 1'b0;
            if (!enable) begin
                state_q <= ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (rx_fall) begin
                            width_q <= CNT_ONE;
                            state_q <= ST_MEASURE;
                        end
                    end
                    ST_MEASURE: begin
                        if (rx_rise) begin
                            if (width_q < CNT_MIN) begin
                                state_q <= ST_IDLE;
                            end else begin
                                period_q  <= width_q;
                                tick_q    <= (width_q >> 1) - CNT_ONE;
                                bit_idx_q <= '0;
                                state_q   <= ST_DATA;
                            end
                        end else if (width_q == CNT_MAX) begin
                            state_q <= ST_IDLE;
                        end else begin
                            width_q <= width_q + CNT_ONE;
                        end
                    end
                    ST_DATA: begin
                        if (tick_done) begin
                            shift_q <= {rx_level, shift_q[ABD_DATA_BITS-1:1]};
                            tick_q  <= period_q - CNT_ONE;
                            if (bit_idx_q == LAST_BIT) begin
                                state_q <= ST_STOP;
                            end else begin
                                bit_idx_q <= bit_idx_q + 1'b1;
                            end
                        end else begin
                            tick_q <= tick_q - CNT_ONE;
                        end
                    end
                    ST_STOP: begin
                        if (tick_done) begin
                            state_q <= ST_IDLE;
                            if (rx_level && char_ok) begin
                                pulse_q      <= 1'b1;
                                out_period_q <= period_q;
                            end
                        end else begin
                            tick_q <= tick_q - CNT_ONE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Registered results to the flag and the divisor output.
    always_comb begin
        lock_pulse  = pulse_q;
        lock_period = out_period_q;
    end

endmodule

// File: rtl/abd_lock_flag.sv
// Sticky completion flag. Set by a lock pulse, cleared by a write of 1 to
// the clear control; a lock in the same cycle as a clear wins.
module abd_lock_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_wr,
    input  logic clr_data,
    output logic flag
);

    logic flag_q;

    // Hold, set or clear the completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_pulse) begin
            flag_q <= 1'b1;
        end else if (clr_wr && clr_data) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/autobaud_detect.sv
// Auto-baud detector top: synchroniser, frame sequencer and sticky flag.
// Assumes an idle-high asynchronous line and sync letters sent with one
// start bit, eight data bits least significant first and a stop bit.
module autobaud_detect #(
    parameter int CNT_W       = 16,
    parameter int MIN_PERIOD  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_i,
    input  logic             align_en_i,
    input  logic             abd_clr_wr_i,
    input  logic             abd_clr_data_i,
    output logic             lock_flag_o,
    output logic [CNT_W-1:0] divisor_o,
    output logic             divisor_vld_o,
    output logic             clr_rdata_o
);

    logic rx_level;
    logic rx_fall;
    logic rx_rise;
    logic lock_pulse;

    abd_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_async(rx_i),
        .rx_level(rx_level),
        .rx_fall (rx_fall),
        .rx_rise (rx_rise)
    );

    abd_frame_fsm #(
        .CNT_W     (CNT_W),
        .MIN_PERIOD(MIN_PERIOD)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (align_en_i),
        .rx_level   (rx_level),
        .rx_fall    (rx_fall),
        .rx_rise    (rx_rise),
        .lock_pulse (lock_pulse),
        .lock_period(divisor_o)
    );

    abd_lock_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_pulse(lock_pulse),
        .clr_wr   (abd_clr_wr_i),
        .clr_data (abd_clr_data_i),
        .flag     (lock_flag_o)
    );

    // The clear control is write-only; its readback is always zero.
    assign divisor_vld_o = lock_pulse;
    assign clr_rdata_o   = 1'b0;

endmodule

// File: rtl/abd_checker.sv
// Port-level properties of the auto-baud detector, bound to the top.
module abd_checker #(
    parameter int CNT_W      = 16,
    parameter int MIN_PERIOD = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             align_en_i,
    input logic             abd_clr_wr_i,
    input logic             abd_clr_data_i,
    input logic             lock_flag_o,
    input logic [CNT_W-1:0] divisor_o,
    input logic             divisor_vld_o,
    input logic             clr_rdata_o
);

    AST_FLAG_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        divisor_vld_o |=> lock_flag_o);  // R1
    AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag_o) |-> $past(divisor_vld_o));  // R1
    AST_CLR_ONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (abd_clr_wr_i && abd_clr_data_i && !divisor_vld_o) |=> !lock_flag_o);  // R2
    AST_CLR_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (abd_clr_wr_i && !abd_clr_data_i && !divisor_vld_o) |=> $stable(lock_flag_o));  // R3
    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_rdata_o);  // R4
    AST_OFF_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !align_en_i |=> !divisor_vld_o);  // R5
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        divisor_vld_o |=> !divisor_vld_o);  // R7
    AST_DIVISOR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !divisor_vld_o |-> $stable(divisor_o));  // R7
    AST_DIVISOR_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        divisor_vld_o |-> (divisor_o >= CNT_W'(MIN_PERIOD)));  // R8

endmodule

bind autobaud_detect abd_checker #(
    .CNT_W     (CNT_W),
    .MIN_PERIOD(MIN_PERIOD)
) u_abd_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .align_en_i    (align_en_i),
    .abd_clr_wr_i  (abd_clr_wr_i),
    .abd_clr_data_i(abd_clr_data_i),
    .lock_flag_o   (lock_flag_o),
    .divisor_o     (divisor_o),
    .divisor_vld_o (divisor_vld_o),
    .clr_rdata_o   (clr_rdata_o)
);

// File: tb/autobaud_detect_tb_top.sv
// Bench: drives serial frames and predicts every output on every clock.
module autobaud_detect_tb_top;

    localparam int CNT_W   = 16;
    localparam int MIN_PER = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx = 1'b1;
    logic             en = 1'b0;
    logic             clr_wr = 1'b0;
    logic             clr_data = 1'b0;
    logic             flag;
    logic [CNT_W-1:0] div;
    logic             vld;
    logic             rdata;

    autobaud_detect #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PER)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .align_en_i(en),
        .abd_clr_wr_i(clr_wr), .abd_clr_data_i(clr_data),
        .lock_flag_o(flag), .divisor_o(div), .divisor_vld_o(vld),
        .clr_rdata_o(rdata)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    model_on = 0;
    int    vld_at = -10;
    int    div_next = 0;
    int    clr_edge = -10;
    bit    clr_one = 0;
    bit    m_flag = 0;
    int    m_div = 0;
    string phase = "R6";

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s (phase %s, cycle %0d): actual %0d expected %0d",
                     req, what, phase, cyc, act, exp);
        end
    endtask

    // Reference model: scheduled lock and clear events, compared each clock.
    always @(negedge clk) begin
        if (model_on) begin
            if (cyc == vld_at) m_div = div_next;
            if (cyc == vld_at + 1) m_flag = 1;
            else if (cyc == clr_edge && clr_one) m_flag = 0;
            check("R7", "valid pulse", 32'(vld), 32'(cyc == vld_at));
            check("R7", "divisor", 32'(div), 32'(m_div));
            check("R1", "flag", 32'(flag), 32'(m_flag));
            check("R4", "clear readback", 32'(rdata), 32'd0);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Start bit, 8 data bits LSB first, stop bit; optional enable drop at a bit.
    task automatic send(logic [7:0] b, int p, bit stop_hi, int drop_bit);
        int c;
        bit lock;
        @(negedge clk);
        rx = 1'b0;
        c = cyc + 1;
        lock = en && (p >= MIN_PER) && (b == 8'h41 || b == 8'h61) && stop_hi && (drop_bit < 0);
        if (lock) begin
            vld_at = c + 9 * p + p / 2 + 2;
            div_next = p;
        end
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            if (i == drop_bit) en = 1'b0;
            rx = b[i];
            repeat (p) @(negedge clk);
        end
        rx = stop_hi;
        repeat (p) @(negedge clk);
        rx = 1'b1;
        if (drop_bit >= 0) en = 1'b1;
        idle(2 * p + 10);
    endtask

    task automatic pulse_low(int n, int gap);
        @(negedge clk);
        rx = 1'b0;
        repeat (n) @(negedge clk);
        rx = 1'b1;
        idle(gap);
    endtask

    task automatic clr(bit d);
        @(negedge clk);
        clr_wr = 1'b1;
        clr_data = d;
        clr_edge = cyc + 1;
        clr_one = d;
        @(negedge clk);
        check("R4", "readback during write", 32'(rdata), 32'd0);
        clr_wr = 1'b0;
        clr_data = 1'b0;
        idle(3);
    endtask

    task automatic run();
        idle(4);
        check("R6", "flag in reset", 32'(flag), 32'd0);
        check("R6", "divisor in reset", 32'(div), 32'd0);
        check("R6", "valid in reset", 32'(vld), 32'd0);
        check("R6", "readback in reset", 32'(rdata), 32'd0);
        rst_n = 1'b1;
        model_on = 1;
        en = 1'b1;
        idle(10);

        phase = "R10 upper A at 8";
        send(8'h41, 8, 1'b1, -1);
        check("R1", "flag after A", 32'(flag), 32'd1);
        check("R7", "divisor after A", 32'(div), 32'd8);

        phase = "R3 write zero";
        clr(1'b0);
        check("R3", "flag kept", 32'(flag), 32'd1);

        phase = "R2 write one";
        clr(1'b1);
        check("R2", "flag cleared", 32'(flag), 32'd0);

        phase = "R9 wrong char";
        send(8'h43, 8, 1'b1, -1);
        check("R9", "flag after C", 32'(flag), 32'd0);
        phase = "R9 low stop";
        send(8'h41, 8, 1'b0, -1);
        check("R9", "flag after framing error", 32'(flag), 32'd0);
        check("R9", "divisor kept", 32'(div), 32'd8);

        phase = "R10 lower a at 13";
        send(8'h61, 13, 1'b1, -1);
        check("R9", "flag after later good a", 32'(flag), 32'd1);
        check("R10", "divisor odd period", 32'(div), 32'd13);
        clr(1'b1);

        phase = "R8 glitches";
        pulse_low(3, 30);
        pulse_low(4, 80);
        check("R8", "flag after glitches", 32'(flag), 32'd0);
        check("R8", "divisor after glitches", 32'(div), 32'd13);
        phase = "R8 minimum period";
        send(8'h41, 4, 1'b1, -1);
        check("R8", "divisor at minimum", 32'(div), 32'd4);
        clr(1'b1);

        phase = "R5 disabled";
        en = 1'b0;
        send(8'h41, 8, 1'b1, -1);
        check("R5", "flag while disabled", 32'(flag), 32'd0);
        check("R5", "divisor while disabled", 32'(div), 32'd4);
        en = 1'b1;
        idle(5);
        phase = "R5 dropped mid-frame";
        send(8'h61, 8, 1'b1, 3);
        check("R5", "flag after abort", 32'(flag), 32'd0);
        phase = "R5 recovery";
        send(8'h41, 10, 1'b1, -1);
        check("R5", "flag after recovery", 32'(flag), 32'd1);
        check("R7", "divisor after recovery", 32'(div), 32'd10);
        idle(10);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (150000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog (all requirements): actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule